// File: doc/BRIEF.md
# Cascadable 32-Source Interrupt Aggregator

The block gathers 32 interrupt request lines into a sticky pending register and gates each pending bit with its own mask bit. It drives one registered wired interrupt toward a parent controller, which can be a top-level processor interrupt controller or another copy of this same block. A chain of these blocks therefore forms a tree of interrupt sources.

Software reaches the block through a plain register port made of a byte address, write data, a write strobe and combinational read data. Three registers are mapped: pending, mask and control. One control bit picks how every source is captured. In level mode, a high input sets its pending bit. In edge mode, only a low-to-high transition sets it. A second control bit is a stored flag for turning off message-signalled delivery. It is kept and read back, but nothing else depends on it.

Software clears a pending bit by writing 0 to it. Writing 1 to a pending bit leaves it unchanged. The inputs are assumed to be synchronous to the block clock already.

Top module: `irqFanInAgg`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads 0xFFFFFFFF, the control register reads 0 and irqOut is 0.
- R2: The pending register is read at byte address 0x00, the mask register at 0x10 and the control register at 0x28. Every other address reads 0. The control register keeps only bits 3 and 5, and all its other bits read 0.
- R3: A mask bit of 1 keeps its pending source off irqOut, and a mask bit of 0 lets it through. With all mask bits at 1, irqOut stays 0.
- R4: A write to address 0x00 clears each pending bit whose data bit is 0 and leaves each pending bit whose data bit is 1 unchanged. Without such a write, no pending bit is cleared.
- R5: With control bit 3 set to 1 (edge mode), a pending bit is set at the clock edge that ends a cycle in which its input is 1 and was 0 in the cycle before. An input held high does not set the bit again after it has been cleared.
- R6: In edge mode, a rising input in the same cycle as a clearing write to its bit wins, and the bit stays set.
- R7: With control bit 3 set to 0 (level mode), a pending bit is set at every edge at which its input is 1. A clearing write while the input is high leaves the bit set.
- R8: irqOut is registered. It goes to 1 one cycle after (pending AND NOT mask) becomes non-zero, and it returns to 0 one cycle after that value becomes zero.
- R9: Control bit 5 is stored and read back, and it has no effect on capture or on irqOut.
- R10: A write to address 0x10 loads all 32 bits of the mask register at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Interrupt request lines, one per source, synchronous to clk |
| regAddr | input | 6 | Byte address of the register access |
| regWrData | input | 32 | Write data |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Registered wired interrupt to the parent controller |

## Verification
The bound checker tests the following on every cycle:
- level capture and edge capture against its own copy of the previous input;
- that pending bits are sticky except under a zero write;
- that the mask loads;
- that a full mask silences irqOut;
- that irqOut never rises without a pending unmasked source in the cycle before;
- that unmapped addresses read zero.

Some behaviours only the bench scenarios can show:
- a clear while a level input is still high;
- a held edge input staying cleared;
- the edge winning over a simultaneous clear;
- the exact one-cycle lag of irqOut after a mask or pending change;
- that the message-disable bit has no effect.

A behavioural model in the bench also compares irqOut and the read data on every cycle.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam int unsigned SrcCount = 32;
  localparam int unsigned AddrWidth = 6;
  localparam logic [AddrWidth-1:0] PendOff = 6'h00;
  localparam logic [AddrWidth-1:0] MaskOff = 6'h10;
  localparam logic [AddrWidth-1:0] CtrlOff = 6'h28;
  localparam int unsigned EdgeBit = 3;
  localparam int unsigned MsgOffBit = 5;

  typedef enum logic [1:0] {
    RdNone,
    RdPend,
    RdMask,
    RdCtrl
  } rdSelT;

  typedef struct packed {
    logic  wrPend;
    logic  wrMask;
    logic  wrCtrl;
    rdSelT rdSel;
  } regStrobeT;
endpackage

// File: rtl/irqAggRegCtl.sv
module irqAggRegCtl
  import irqAggPkg::*;
#(
  parameter int unsigned AddrW = AddrWidth
) (
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWrEn,
  output regStrobeT        strobes
);
  logic hitPend;
  logic hitMask;
  logic hitCtrl;

  always_comb begin
    hitPend = (regAddr == AddrW'(PendOff));
    hitMask = (regAddr == AddrW'(MaskOff));
    hitCtrl = (regAddr == AddrW'(CtrlOff));
    strobes.wrPend = regWrEn && hitPend;
    strobes.wrMask = regWrEn && hitMask;
    strobes.wrCtrl = regWrEn && hitCtrl;
    if (hitPend)      strobes.rdSel = RdPend;
    else if (hitMask) strobes.rdSel = RdMask;
    else if (hitCtrl) strobes.rdSel = RdCtrl;
    else              strobes.rdSel = RdNone;
  end
endmodule

// File: rtl/irqAggCell.sv
module irqAggCell (
  input  logic clk,
  input  logic rstN,
  input  logic reqIn,
  input  logic edgeMode,
  input  logic clrReq,
  output logic pendQ
);
  logic prevQ;
  logic setHit;

  always_comb begin
    if (edgeMode) setHit = reqIn && !prevQ;
    else          setHit = reqIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      prevQ <= reqIn;
      if (setHit)      pendQ <= 1'b1;
      else if (clrReq) pendQ <= 1'b0;
    end
  end
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int unsigned NumSrc = SrcCount
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] irqIn,
  input  logic [NumSrc-1:0] regWrData,
  input  regStrobeT         strobes,
  output logic [NumSrc-1:0] regRdData,
  output logic [NumSrc-1:0] pendVec,
  output logic [NumSrc-1:0] maskVec,
  output logic              edgeMode,
  output logic              irqOut
);
  localparam logic [NumSrc-1:0] CtrlKeep =
    (NumSrc'(1) << EdgeBit) | (NumSrc'(1) << MsgOffBit);

  logic [NumSrc-1:0] ctrlQ;
  logic              anyLive;

  assign edgeMode = ctrlQ[EdgeBit];

  for (genvar i = 0; i < NumSrc; i++) begin : gSrc
    irqAggCell uCell (
      .clk      (clk),
      .rstN     (rstN),
      .reqIn    (irqIn[i]),
      .edgeMode (edgeMode),
      .clrReq   (strobes.wrPend && !regWrData[i]),
      .pendQ    (pendVec[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskVec <= '1;
      ctrlQ   <= '0;
    end else begin
      if (strobes.wrMask) maskVec <= regWrData;
      if (strobes.wrCtrl) ctrlQ   <= regWrData & CtrlKeep;
    end
  end

  assign anyLive = |(pendVec & ~maskVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= anyLive;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RdPend:  regRdData = pendVec;
      RdMask:  regRdData = maskVec;
      RdCtrl:  regRdData = ctrlQ;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irqFanInAgg.sv
module irqFanInAgg
  import irqAggPkg::*;
#(
  parameter int unsigned NumSrc = SrcCount,
  parameter int unsigned AddrW  = AddrWidth
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] irqIn,
  input  logic [AddrW-1:0]  regAddr,
  input  logic [NumSrc-1:0] regWrData,
  input  logic              regWrEn,
  output logic [NumSrc-1:0] regRdData,
  output logic              irqOut
);
  regStrobeT         strobes;
  logic [NumSrc-1:0] pendVec;
  logic [NumSrc-1:0] maskVec;
  logic              edgeMode;

  irqAggRegCtl #(.AddrW(AddrW)) uCtl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  irqAggDatapath #(.NumSrc(NumSrc)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .regWrData (regWrData),
    .strobes   (strobes),
    .regRdData (regRdData),
    .pendVec   (pendVec),
    .maskVec   (maskVec),
    .edgeMode  (edgeMode),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irqAggChk.sv
module irqAggChk
  import irqAggPkg::*;
#(
  parameter int unsigned NumSrc = SrcCount,
  parameter int unsigned AddrW  = AddrWidth
) (
  input logic              clk,
  input logic              rstN,
  input logic [NumSrc-1:0] irqIn,
  input logic [AddrW-1:0]  regAddr,
  input logic [NumSrc-1:0] regWrData,
  input logic              regWrEn,
  input logic [NumSrc-1:0] regRdData,
  input logic              irqOut,
  input logic [NumSrc-1:0] pendVec,
  input logic [NumSrc-1:0] maskVec,
  input logic              edgeMode
);
  logic [NumSrc-1:0] prevChk;
  logic              pendWrite;
  logic              maskWrite;
  logic              unmapped;
  logic [NumSrc-1:0] riseChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevChk <= '0;
    else       prevChk <= irqIn;
  end

  assign riseChk   = irqIn & ~prevChk;
  assign pendWrite = regWrEn && (regAddr == AddrW'(0));
  assign maskWrite = regWrEn && (regAddr == AddrW'(16));
  assign unmapped  = (regAddr != AddrW'(0)) && (regAddr != AddrW'(16)) && (regAddr != AddrW'(40));

  AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !edgeMode |=> ((pendVec & $past(irqIn)) == $past(irqIn))); // R7

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    edgeMode |=> ((pendVec & $past(riseChk)) == $past(riseChk))); // R5

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (edgeMode && pendWrite && (riseChk != '0)) |=> ((pendVec & $past(riseChk)) == $past(riseChk))); // R6

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !pendWrite |=> ((pendVec & $past(pendVec)) == $past(pendVec))); // R4

  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    pendWrite |=> ((pendVec & $past(pendVec & regWrData)) == $past(pendVec & regWrData))); // R4

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    maskWrite |=> (maskVec == $past(regWrData))); // R10

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskVec) == '1) |-> !irqOut); // R3

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(pendVec & ~maskVec) != '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> (regRdData == '0)); // R2
endmodule

bind irqFanInAgg irqAggChk #(.NumSrc(NumSrc), .AddrW(AddrW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .irqIn     (irqIn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regWrEn   (regWrEn),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .pendVec   (pendVec),
  .maskVec   (maskVec),
  .edgeMode  (edgeMode)
);

// File: tb/tb_irqFanInAgg.sv
`timescale 1ns/100ps
module tb_irqFanInAgg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mPend = '0;
  logic [31:0] mMask = '1;
  logic [31:0] mCtrl = '0;
  logic [31:0] mPrev = '0;
  logic        mOut  = 1'b0;

  irqFanInAgg dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    if (a == 6'h00) return mPend;
    if (a == 6'h10) return mMask;
    if (a == 6'h28) return mCtrl;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] base;
    logic [31:0] add;
    if (!rstN) begin
      mPend = '0; mMask = '1; mCtrl = '0; mPrev = '0; mOut = 1'b0;
    end else begin
      base = (regWrEn && regAddr == 6'h00) ? (mPend & regWrData) : mPend;
      add  = mCtrl[3] ? (irqIn & ~mPrev) : irqIn;
      mOut = |(mPend & ~mMask);
      mPend = base | add;
      if (regWrEn && regAddr == 6'h10) mMask = regWrData;
      if (regWrEn && regAddr == 6'h28) mCtrl = regWrData & 32'h28;
      mPrev = irqIn;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      checks++;
      if (irqOut !== mOut) begin
        errors++;
        $display("FAIL R8 model irqOut actual %0b expected %0b at %0t", irqOut, mOut, $time);
      end
      checks++;
      if (regRdData !== modelRead(regAddr)) begin
        errors++;
        $display("FAIL R2 model read addr %h actual %h expected %h", regAddr, regRdData, modelRead(regAddr));
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s read addr %h actual %h expected %h", tag, a, regRdData, exp);
    end
  endtask

  task automatic chkOut(input logic exp, input string tag);
    #1;
    checks++;
    if (irqOut !== exp) begin
      errors++;
      $display("FAIL %s irqOut actual %0b expected %0b", tag, irqOut, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    chk(6'h00, 32'h0, "R1");
    chk(6'h10, 32'hFFFF_FFFF, "R1");
    chk(6'h28, 32'h0, "R1");
    chkOut(1'b0, "R1");
    // R2 unmapped and control bit keep
    chk(6'h04, 32'h0, "R2");
    chk(6'h3C, 32'h0, "R2");
    wr(6'h28, 32'hFFFF_FFFF);
    chk(6'h28, 32'h28, "R2");
    wr(6'h28, 32'h20);
    chk(6'h28, 32'h20, "R9");
    // R7 level capture of a one-cycle pulse
    @(negedge clk); irqIn = 32'h1;
    @(negedge clk); irqIn = 32'h0;
    chk(6'h00, 32'h1, "R7");
    repeat (2) @(negedge clk);
    chkOut(1'b0, "R3");
    // R3 / R8 unmasking and output lag
    wr(6'h10, 32'hFFFF_FFFE);
    chkOut(1'b0, "R8");
    @(negedge clk);
    chkOut(1'b1, "R3");
    // R4 write one keeps, write zero clears
    wr(6'h00, 32'hFFFF_FFFF);
    chk(6'h00, 32'h1, "R4");
    wr(6'h00, 32'hFFFF_FFFE);
    chkOut(1'b1, "R8");
    chk(6'h00, 32'h0, "R4");
    chkOut(1'b0, "R8");
    // R7 clear while level input high
    @(negedge clk); irqIn = 32'h2;
    wr(6'h00, 32'h0);
    chk(6'h00, 32'h2, "R7");
    @(negedge clk); irqIn = 32'h0;
    wr(6'h00, 32'h0);
    chk(6'h00, 32'h0, "R7");
    // R5 edge mode
    wr(6'h28, 32'h28);
    @(negedge clk); irqIn = 32'h4;
    chk(6'h00, 32'h4, "R5");
    wr(6'h00, 32'h0);
    chk(6'h00, 32'h0, "R5");
    repeat (2) @(negedge clk);
    chk(6'h00, 32'h0, "R5");
    @(negedge clk); irqIn = 32'h0;
    @(negedge clk); irqIn = 32'h4;
    chk(6'h00, 32'h4, "R5");
    // R6 edge wins over simultaneous clear
    @(negedge clk); irqIn = 32'h0;
    @(negedge clk);
    irqIn = 32'h8; regAddr = 6'h00; regWrData = 32'h0; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    chk(6'h00, 32'h8, "R6");
    repeat (2) @(negedge clk);
    chkOut(1'b0, "R3");
    wr(6'h10, 32'hFFFF_FFF7);
    @(negedge clk);
    chkOut(1'b1, "R3");
    // R9 message-disable bit has no effect
    wr(6'h28, 32'h08);
    chk(6'h00, 32'h8, "R9");
    chkOut(1'b1, "R9");
    chk(6'h28, 32'h08, "R9");
    // R10 full mask load
    wr(6'h10, 32'h1234_5678);
    chk(6'h10, 32'h1234_5678, "R10");
    @(negedge clk);
    chkOut(1'b0, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule